// File: doc/BRIEF.md
# Byte-Stream Word Reassembler

This block sits after an 8b/10b receive path and turns a stream of decoded bytes back into the wide words that a serializer on the far side split up. Each cycle it may get one byte. The byte comes with two flags: one marks it as a control character, and the other says whether the receive path is locked. While the path is locked, data bytes are collected in arrival order. The first byte of a word becomes the most significant byte. When the last byte of a word arrives, the reassembled word is presented together with a single-cycle strobe.

Any control character is a framing marker. It returns the byte position to the start of a word. If a control character cuts into a word that is only partly received, the partial word is discarded and a one-cycle abort pulse is raised. The word width is a parameter. The sender pads it up to whole bytes at the least significant end, and this block strips that padding, so the output carries exactly the parameter's number of bits. The output is only promised during the strobe cycle, so downstream logic latches it there.

Top module: `byte_word_deser`

## Requirements
- R1: A byte presented while `rx_synced` is low has no effect at all, whether it is a data byte or a control byte. It does not move the byte position, it raises no strobe or abort, and it does not enter any word.
- R2: A byte with `rx_synced`=1 and `rx_is_ctrl`=1 returns the byte position to the first byte of a word. The control byte contributes no data, and any number of control bytes in a row raise no abort.
- R3: A word is made of NBYTES = ceil(WORD_W/8) data bytes taken with `rx_synced`=1 and `rx_is_ctrl`=0, counted in arrival order.
- R4: In the cycle after the clock edge that takes the NBYTES-th data byte of a word, `word_strobe` is 1. It is high for exactly that one cycle, and it is 0 in every other cycle.
- R5: During the strobe, `word_out` equals the padded word {byte0, byte1, ..., byte(NBYTES-1)} shifted right by NBYTES*8-WORD_W bits. Byte0 is the first data byte received and sits at the most significant end; the low padding bits are dropped. With WORD_W=20 this gives `word_out` = {byte0, byte1, byte2[7:4]}.
- R6: A control byte taken after 1 to NBYTES-1 data bytes of a word discards those bytes. No strobe is raised for the discarded word, and the next NBYTES data bytes form a complete new word.
- R7: `frame_abort` is 1 for exactly the cycle after a control byte that is taken while the byte position is not at the first byte. It is 0 in every other cycle, including after a control byte taken at the first byte position.
- R8: While `rst` is high on a clock edge, the byte position returns to the first byte, and in the following cycle `word_strobe`=0, `frame_abort`=0 and `word_out`=0. Bytes received before the reset never reach a later word.
- R9: Words may follow each other with no control byte between them. After a word completes, the next data byte begins a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive byte clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte | input | 8 | Decoded byte from the receive path |
| rx_is_ctrl | input | 1 | 1 when `rx_byte` is a control character |
| rx_synced | input | 1 | 1 when the receive path is locked and the byte is meaningful |
| word_out | output | WORD_W | Reassembled word, valid while `word_strobe` is 1 |
| word_strobe | output | 1 | One-cycle pulse marking a complete word |
| frame_abort | output | 1 | One-cycle pulse when a control byte cut into a partial word |

## Verification
The bench builds the block with WORD_W=20. That gives three bytes per word and four padding bits, so the bit stripping is exercised on every word. With only three positions per word, the bench can place a control byte at every byte position. The data sweep also walks every byte value through the word positions, and the bench mixes in unsynced data and control bytes and resets in the middle of a word. Expected words, strobes and aborts come from an arithmetic model of the byte position in the bench.

// File: rtl/deser_pkg.sv
package deser_pkg;

    // What the qualified byte stream carries in one cycle.
    typedef enum logic [1:0] {
        EV_IDLE = 2'd0,
        EV_DATA = 2'd1,
        EV_CTRL = 2'd2
    } rx_ev_e;

    typedef struct packed {
        rx_ev_e     kind;
        logic [7:0] byte_val;
    } rx_ev_t;

    localparam int BYTE_W = 8;

    // Number of whole bytes needed to carry a word of the given width.
    function automatic int bytes_for(input int width);
        return (width + BYTE_W - 1) / BYTE_W;
    endfunction

endpackage

// File: rtl/deser_event_gate.sv
module deser_event_gate
    import deser_pkg::*;
(
    input  logic       rx_synced,
    input  logic       rx_is_ctrl,
    input  logic [7:0] rx_byte,
    output rx_ev_t     ev
);

    // Drops everything while unlocked, then splits the stream into data and framing.
    always_comb begin
        ev.byte_val = rx_byte;
        if (!rx_synced) begin
            ev.kind = EV_IDLE;
        end else if (rx_is_ctrl) begin
            ev.kind = EV_CTRL;
        end else begin
            ev.kind = EV_DATA;
        end
    end

endmodule

// File: rtl/deser_frame_tracker.sv
module deser_frame_tracker
    import deser_pkg::*;
#(
    parameter int NBYTES = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  rx_ev_e kind,
    output logic   last_byte,
    output logic   abort_pulse
);

    localparam logic [NBYTES-1:0] FIRST_POS = NBYTES'(1);

    // One-hot byte position, one bit per byte of the padded word.
    logic [NBYTES-1:0] pos_q;

    assign last_byte = (kind == EV_DATA) && pos_q[NBYTES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q       <= FIRST_POS;
            abort_pulse <= 1'b0;
        end else begin
            abort_pulse <= 1'b0;
            case (kind)
                EV_CTRL: begin
                    abort_pulse <= !pos_q[0];
                    pos_q       <= FIRST_POS;
                end
                EV_DATA: begin
                    // Rotation wraps to the first position after the last byte.
                    pos_q <= (pos_q << 1) | (pos_q >> (NBYTES - 1));
                end
                default: begin
                    pos_q <= pos_q;
                end
            endcase
        end
    end

    AST_POS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(pos_q) == 1); // R3

    AST_CTRL_REWINDS: assert property (@(posedge clk) disable iff (rst)
        (kind == EV_CTRL) |=> pos_q[0]); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (kind == EV_IDLE) |=> $stable(pos_q)); // R1

    AST_ABORT_AT_START: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |-> pos_q[0]); // R7

endmodule

// File: rtl/deser_word_assembler.sv
module deser_word_assembler
    import deser_pkg::*;
#(
    parameter int WORD_W = 20,
    parameter int NBYTES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  rx_ev_t            ev,
    input  logic              last_byte,
    output logic [WORD_W-1:0] word_q,
    output logic              strobe_q
);

    localparam int PADDED_W = NBYTES * BYTE_W;
    localparam int HOLD_W   = (NBYTES - 1) * BYTE_W;

    logic [PADDED_W-1:0] padded;

    generate
        if (NBYTES > 1) begin : g_multi
            logic [HOLD_W-1:0] hold_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    hold_q <= '0;
                end else if (ev.kind == EV_DATA) begin
                    hold_q <= HOLD_W'({hold_q, ev.byte_val});
                end
            end

            assign padded = {hold_q, ev.byte_val};

            AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
                strobe_q |=> !strobe_q); // R4
        end else begin : g_single
            assign padded = ev.byte_val;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q   <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= last_byte;
            if (last_byte) begin
                word_q <= padded[PADDED_W-1 -: WORD_W];
            end
        end
    end

endmodule

// File: rtl/byte_word_deser.sv
module byte_word_deser
    import deser_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        rx_byte,
    input  logic              rx_is_ctrl,
    input  logic              rx_synced,
    output logic [WORD_W-1:0] word_out,
    output logic              word_strobe,
    output logic              frame_abort
);

    localparam int NBYTES = bytes_for(WORD_W);

    rx_ev_t ev;
    logic   last_byte;

    deser_event_gate u_gate (
        .rx_synced  (rx_synced),
        .rx_is_ctrl (rx_is_ctrl),
        .rx_byte    (rx_byte),
        .ev         (ev)
    );

    deser_frame_tracker #(
        .NBYTES (NBYTES)
    ) u_track (
        .clk         (clk),
        .rst         (rst),
        .kind        (ev.kind),
        .last_byte   (last_byte),
        .abort_pulse (frame_abort)
    );

    deser_word_assembler #(
        .WORD_W (WORD_W),
        .NBYTES (NBYTES)
    ) u_asm (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .last_byte (last_byte),
        .word_q    (word_out),
        .strobe_q  (word_strobe)
    );

    AST_ABORT_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        frame_abort |-> !word_strobe); // R6

    AST_UNSYNCED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rx_synced |=> (!word_strobe && !frame_abort)); // R1

endmodule

// File: tb/byte_word_deser_tb_top.sv
module byte_word_deser_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 20;
    localparam int NB         = (WORD_W + 7) / 8;
    localparam int PAD        = NB * 8 - WORD_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [7:0]        rx_byte = '0;
    logic              rx_is_ctrl = 1'b0;
    logic              rx_synced = 1'b0;
    logic [WORD_W-1:0] word_out;
    logic              word_strobe;
    logic              frame_abort;

    int total = 0;
    int bad   = 0;
    int mcount = 0;
    logic [7:0] mb [NB];

    always #(CLK_PERIOD / 2) clk = ~clk;

    byte_word_deser #(.WORD_W(WORD_W)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .rx_byte     (rx_byte),
        .rx_is_ctrl  (rx_is_ctrl),
        .rx_synced   (rx_synced),
        .word_out    (word_out),
        .word_strobe (word_strobe),
        .frame_abort (frame_abort)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drives one cycle, advances the model, then samples just after the edge.
    task automatic cyc(input string req, input logic r, input logic [7:0] b,
                       input logic c, input logic s);
        logic              exp_str;
        logic              exp_ab;
        logic [WORD_W-1:0] exp_w;
        logic [NB*8-1:0]   padded;
        rst = r; rx_byte = b; rx_is_ctrl = c; rx_synced = s;
        exp_str = 1'b0; exp_ab = 1'b0; exp_w = '0;
        if (r) begin
            mcount = 0;
        end else if (s) begin
            if (c) begin
                exp_ab = (mcount != 0);
                mcount = 0;
            end else begin
                mb[mcount] = b;
                mcount++;
                if (mcount == NB) begin
                    exp_str = 1'b1;
                    padded = '0;
                    for (int k = 0; k < NB; k++) padded = (padded << 8) | (NB*8)'(mb[k]);
                    exp_w = WORD_W'(padded >> PAD);
                    mcount = 0;
                end
            end
        end
        @(posedge clk);
        #1;
        chk(r ? "R8" : "R4", "word_strobe", 64'(word_strobe), 64'(exp_str));
        chk(r ? "R8" : "R7", "frame_abort", 64'(frame_abort), 64'(exp_ab));
        if (r) chk("R8", "word_out after reset", 64'(word_out), 64'(0));
        else if (exp_str) chk(req, "word_out", 64'(word_out), 64'(exp_w));
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        bad++;
        total++;
        $display("FAIL watchdog run did not finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(posedge clk);
        #1;
        // R8: reset state
        cyc("R8", 1'b1, 8'h00, 1'b0, 1'b0);
        cyc("R8", 1'b1, 8'h5A, 1'b0, 1'b1);

        // R3, R5, R9: back-to-back words walking every byte value
        for (int v = 0; v < 256; v++) cyc("R5", 1'b0, 8'(v), 1'b0, 1'b1);
        for (int v = 0; v < 3 * NB - (256 % NB); v++)
            cyc("R9", 1'b0, 8'(v * 37 + 11), 1'b0, 1'b1);

        // R1: unsynced data and control bytes scattered inside words
        for (int w = 0; w < 12; w++) begin
            for (int k = 0; k < NB; k++) begin
                cyc("R1", 1'b0, 8'(w * 53 + k * 29 + 7), 1'b0, 1'b1);
                cyc("R1", 1'b0, 8'(w * 17 + k), 1'(k + w), 1'b0);
            end
        end

        // R6, R7: control byte at every position of a word, then a full word
        for (int p = 0; p < NB; p++) begin
            for (int k = 0; k < p; k++) cyc("R6", 1'b0, 8'(p * 71 + k), 1'b0, 1'b1);
            cyc("R7", 1'b0, 8'hBC, 1'b1, 1'b1);
            for (int k = 0; k < NB; k++) cyc("R6", 1'b0, 8'(p * 13 + k * 90), 1'b0, 1'b1);
        end

        // R2: a run of control bytes, then words
        for (int k = 0; k < 4; k++) cyc("R2", 1'b0, 8'hBC, 1'b1, 1'b1);
        for (int k = 0; k < 2 * NB; k++) cyc("R2", 1'b0, 8'(k * 97 + 3), 1'b0, 1'b1);

        // R8: reset in the middle of a word, then a fresh word
        cyc("R8", 1'b0, 8'hA1, 1'b0, 1'b1);
        cyc("R8", 1'b0, 8'hB2, 1'b0, 1'b1);
        cyc("R8", 1'b1, 8'hC3, 1'b0, 1'b1);
        for (int k = 0; k < NB; k++) cyc("R8", 1'b0, 8'(8'hE0 + k), 1'b0, 1'b1);
        cyc("R4", 1'b0, 8'h00, 1'b0, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule